// File: doc/BRIEF.md
# Folded-Bitline DRAM Block with Open-TSV Fault Injection

This block is a cycle-level, synthesizable stand-in for a small stacked DRAM array. Memory test logic uses it as a target. Each cell holds one bit. Each column has a true bitline and a complement bitline. Whether a row's cells sit on the true or the complement line depends on the row index, with a period of four rows. A write completes in the cycle its strobe is accepted. A read walks through four fixed-length phases: precharge, wordline access, sense and restore. Its data appears on a one-cycle valid pulse.

A configuration port can plant one full-open defect in the vertical via of either a wordline or a bitline. The block then reproduces, at logic level, the functional faults such a defect causes:

- Accessing a wordline-open row reaches no cell at all.
- Accessing a row next to it also reaches the floating cell in the same column. This can flip the sensed value and the restored value.
- A cell on an open bitline cannot be written, and its read result is decided by coupling from the two neighbouring columns.

The defect settings are copied into each read when its strobe is accepted. A configuration change therefore never alters an access already under way.

Top module: `dram_tsv_fault_model`

## Requirements
- R1: After reset every cell holds 0, `rd_valid`, `busy` and `dbg_noaccess` are low, and no defect is active (kind 0, reference value 0).
- R2: With no defect, a write stores `op_wdata` at (`op_row`, `op_col`) and a read returns the stored bit. `rd_valid` is a one-cycle pulse exactly 4*PHASE_CYC cycles after the edge that accepts the read strobe, and `busy` is high from that edge until the pulse.
- R3: An `op_valid` strobe, read or write, that arrives while `busy` is high is ignored and changes no cell.
- R4: With a wordline defect (kind 1) at row W, a write to row W changes nothing. A read of row W returns the configured reference bit with `dbg_noaccess` high alongside `rd_valid`.
- R5: Row r places its cells on the complement line when r mod 4 is 1 or 2, and on the true line otherwise. Reading a row adjacent to W when both rows are on the same line, with the accessed cell at 1 and the floating cell (W, same column) at 0, returns 0 and leaves the accessed cell at 0.
- R6: Reading a row adjacent to W that is on the opposite line, with both the accessed and the floating cell at 0, returns 1 and leaves the accessed cell at 1. Every other value combination reads correctly.
- R7: Reads and writes on rows adjacent to W never change any cell of row W.
- R8: With a bitline defect (kind 2), the index is 2*column + line, with line 0 for true and 1 for complement. Reading a row whose cells sit on the other line of that column returns the stored bit.
- R9: Reading the open line's cell returns the left neighbour's (column-1) bit when the two neighbours differ. When they are equal it returns their common value. Column 0 takes column 1, and the last column takes the column before it. The cell itself is left unchanged.
- R10: A write to a cell on the open bitline stores 0, whatever the written value.
- R11: `cfg_we` loads kind, index and reference bit, and kind 3 acts as no defect. A read already accepted uses the settings that were in force at its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_write | input | 1 | 1 = write, 0 = read |
| op_row | input | RAW | Row address |
| op_col | input | CAW | Column address |
| op_wdata | input | 1 | Write data |
| rd_valid | output | 1 | Read result pulse |
| rd_data | output | 1 | Read result |
| busy | output | 1 | Read in progress |
| dbg_noaccess | output | 1 | Read hit a wordline-open row |
| cfg_we | input | 1 | Load defect settings |
| cfg_kind | input | 2 | 0 none, 1 wordline, 2 bitline, 3 none |
| cfg_index | input | IDXW | Defect row, or 2*column+line |
| cfg_ref | input | 1 | Bit reported on a no-access read |

## Verification
The assertions check on every cycle the timing behaviour of the block:

- The phase order is followed, and `busy` is held until the restore phase ends.
- The read latency is counted exactly.
- The frozen defect settings stay stable during a read.
- The no-access flag only appears with a result pulse.
- The array holds still when no write is enabled.
- A restore never lands on the open wordline row.

Which value a read returns under each fault depends on neighbouring cell contents and on the line placement. Only the bench's scenarios can show this: they preset the same-line and opposite-line neighbours, the left and right bitline neighbours and the edge columns, and apply a configuration change while a read is in flight.

// File: rtl/dram_flt_pkg.sv
package dram_flt_pkg;

  typedef enum logic [1:0] {
    DEF_NONE     = 2'd0,
    DEF_WORDLINE = 2'd1,
    DEF_BITLINE  = 2'd2,
    DEF_RSVD     = 2'd3
  } defect_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_ACC  = 3'd2,
    PH_SNS  = 3'd3,
    PH_RST  = 3'd4
  } phase_e;

  // Line placement: complement line for rows whose index mod 4 is 1 or 2.
  function automatic logic row_on_comp(input int row);
    return ((row % 4) == 1) || ((row % 4) == 2);
  endfunction

  function automatic logic wl_blocks(input defect_kind_e kind, input int idx, input int row);
    return (kind == DEF_WORDLINE) && (idx == row);
  endfunction

  function automatic logic wl_is_neighbour(input defect_kind_e kind, input int idx,
                                           input int row, input int rows);
    return (kind == DEF_WORDLINE) && (idx < rows) && ((row == idx + 1) || (idx == row + 1));
  endfunction

  // Cell at (row,col) sits on the open bitline selected by idx = 2*col + line.
  function automatic logic bl_open_cell(input defect_kind_e kind, input int idx,
                                        input int row, input int col);
    return (kind == DEF_BITLINE) && ((idx / 2) == col) &&
           (row_on_comp(row) == ((idx % 2) == 1));
  endfunction

  // Result {fault, value} when a floating cell joins the accessed cell.
  function automatic logic [1:0] wl_neighbour_read(input logic same_line, input logic acc,
                                                   input logic flt);
    if (same_line && acc && !flt) return 2'b10;
    if (!same_line && !acc && !flt) return 2'b11;
    return {1'b0, acc};
  endfunction

  // Value an open bitline settles to from its two column neighbours.
  function automatic logic couple_pick(input logic has_lo, input logic has_hi,
                                       input logic lo, input logic hi);
    if (has_lo && has_hi) return (lo != hi) ? lo : hi;
    if (has_lo) return lo;
    return hi;
  endfunction

endpackage

// File: rtl/dram_phase_seq.sv
module dram_phase_seq import dram_flt_pkg::*; #(
  parameter int PHASE_CYC = 1,
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == CW'(PHASE_CYC - 1));
  assign busy = (phase != PH_IDLE);
  assign done = (phase == PH_RST) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      cnt <= '0;
      if (start) phase <= PH_PRE;
    end else if (last) begin
      cnt <= '0;
      unique case (phase)
        PH_PRE:  phase <= PH_ACC;
        PH_ACC:  phase <= PH_SNS;
        PH_SNS:  phase <= PH_RST;
        default: phase <= PH_IDLE;
      endcase
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R2
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PRE && last) |=> (phase == PH_ACC));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int RAW = $clog2(ROWS),
  localparam int CAW = $clog2(COLS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [RAW-1:0]             wr_row,
  input  logic [CAW-1:0]             wr_col,
  input  logic                       wr_bit,
  output logic [ROWS-1:0][COLS-1:0]  cells
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] row_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) row_q <= '0;
      else if (wr_en && (wr_row == RAW'(r))) row_q[wr_col] <= wr_bit;
    end
    assign cells[r] = row_q;
  end

  // R4
  cells_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cells));

endmodule

// File: rtl/dram_fault_eval.sv
module dram_fault_eval import dram_flt_pkg::*; #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int IDXW = 4,
  localparam int RAW = $clog2(ROWS),
  localparam int CAW = $clog2(COLS)
) (
  input  logic [ROWS-1:0][COLS-1:0] cells,
  input  logic [RAW-1:0]            row,
  input  logic [CAW-1:0]            col,
  input  defect_kind_e              kind,
  input  logic [IDXW-1:0]           idx,
  input  logic                      ref_val,
  output logic                      rd_bit,
  output logic                      rst_bit,
  output logic                      no_access,
  output logic                      multi_hit
);

  logic [RAW-1:0] widx;
  logic [CAW-1:0] lo_c, hi_c;
  logic           acc, flt, lo_v, hi_v, nb;
  logic [1:0]     wl_res;

  always_comb begin
    widx   = idx[RAW-1:0];
    lo_c   = col - CAW'(1);
    hi_c   = col + CAW'(1);
    acc    = cells[row][col];
    flt    = cells[widx][col];
    lo_v   = cells[row][lo_c];
    hi_v   = cells[row][hi_c];
    nb     = wl_is_neighbour(kind, int'(idx), int'(row), ROWS);
    wl_res = wl_neighbour_read(row_on_comp(int'(row)) == row_on_comp(int'(idx)), acc, flt);

    rd_bit    = acc;
    rst_bit   = acc;
    no_access = 1'b0;
    multi_hit = nb && wl_res[1];

    if (wl_blocks(kind, int'(idx), int'(row))) begin
      rd_bit    = ref_val;
      no_access = 1'b1;
    end else if (multi_hit) begin
      rd_bit  = wl_res[0];
      rst_bit = wl_res[0];
    end else if (bl_open_cell(kind, int'(idx), int'(row), int'(col))) begin
      rd_bit = couple_pick(col != '0, col != CAW'(COLS - 1), lo_v, hi_v);
    end
  end

endmodule

// File: rtl/dram_tsv_fault_model.sv
module dram_tsv_fault_model import dram_flt_pkg::*; #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int PHASE_CYC = 1,
  localparam int RAW  = $clog2(ROWS),
  localparam int CAW  = $clog2(COLS),
  localparam int IDXW = (RAW > CAW + 1) ? RAW : CAW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic            op_write,
  input  logic [RAW-1:0]  op_row,
  input  logic [CAW-1:0]  op_col,
  input  logic            op_wdata,
  output logic            rd_valid,
  output logic            rd_data,
  output logic            busy,
  output logic            dbg_noaccess,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_kind,
  input  logic [IDXW-1:0] cfg_index,
  input  logic            cfg_ref
);

  localparam int READ_LAT = 4 * PHASE_CYC;

  // Live defect settings
  defect_kind_e    cfg_kind_q;
  logic [IDXW-1:0] cfg_idx_q;
  logic            cfg_ref_q;

  // Settings and address frozen for the read in flight
  defect_kind_e    kind_q;
  logic [IDXW-1:0] idx_q;
  logic            ref_q;
  logic [RAW-1:0]  row_q;
  logic [CAW-1:0]  col_q;

  logic start_rd, start_wr, seq_done, wr_blocked, wr_decay;
  logic arr_wr_en, arr_wr_bit;
  logic [RAW-1:0] arr_wr_row;
  logic [CAW-1:0] arr_wr_col;
  logic [ROWS-1:0][COLS-1:0] cells;
  logic ev_rd, ev_rst, ev_noacc, ev_multi;

  assign start_rd   = op_valid && !op_write && !busy;
  assign start_wr   = op_valid && op_write && !busy;
  assign wr_blocked = wl_blocks(cfg_kind_q, int'(cfg_idx_q), int'(op_row));
  assign wr_decay   = bl_open_cell(cfg_kind_q, int'(cfg_idx_q), int'(op_row), int'(op_col));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_kind_q <= DEF_NONE;
      cfg_idx_q  <= '0;
      cfg_ref_q  <= 1'b0;
    end else if (cfg_we) begin
      cfg_kind_q <= defect_kind_e'(cfg_kind);
      cfg_idx_q  <= cfg_index;
      cfg_ref_q  <= cfg_ref;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= DEF_NONE;
      idx_q  <= '0;
      ref_q  <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
    end else if (start_rd) begin
      kind_q <= cfg_kind_q;
      idx_q  <= cfg_idx_q;
      ref_q  <= cfg_ref_q;
      row_q  <= op_row;
      col_q  <= op_col;
    end
  end

  dram_phase_seq #(.PHASE_CYC(PHASE_CYC)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_rd),
    .busy  (busy),
    .done  (seq_done)
  );

  dram_fault_eval #(.ROWS(ROWS), .COLS(COLS), .IDXW(IDXW)) u_eval (
    .cells     (cells),
    .row       (row_q),
    .col       (col_q),
    .kind      (kind_q),
    .idx       (idx_q),
    .ref_val   (ref_q),
    .rd_bit    (ev_rd),
    .rst_bit   (ev_rst),
    .no_access (ev_noacc),
    .multi_hit (ev_multi)
  );

  // Single array port: restore at the end of a read, otherwise the idle write.
  always_comb begin
    if (seq_done) begin
      arr_wr_en  = !ev_noacc;
      arr_wr_row = row_q;
      arr_wr_col = col_q;
      arr_wr_bit = ev_rst;
    end else begin
      arr_wr_en  = start_wr && !wr_blocked;
      arr_wr_row = op_row;
      arr_wr_col = op_col;
      arr_wr_bit = wr_decay ? 1'b0 : op_wdata;
    end
  end

  dram_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (arr_wr_en),
    .wr_row (arr_wr_row),
    .wr_col (arr_wr_col),
    .wr_bit (arr_wr_bit),
    .cells  (cells)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid     <= 1'b0;
      rd_data      <= 1'b0;
      dbg_noaccess <= 1'b0;
    end else begin
      rd_valid     <= seq_done;
      dbg_noaccess <= seq_done && ev_noacc;
      if (seq_done) rd_data <= ev_rd;
    end
  end

  // Checker-side latency counter
  int lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_cnt <= 0;
    else if (start_rd) lat_cnt <= 1;
    else if (busy && !seq_done) lat_cnt <= lat_cnt + 1;
  end

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (lat_cnt == READ_LAT));

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R4
  noacc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_noaccess |-> rd_valid);

  // R7
  float_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && arr_wr_en && (ev_multi || kind_q == DEF_WORDLINE)) |-> (int'(row_q) != int'(idx_q)));

  // R11
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(kind_q) && $stable(idx_q) && $stable(ref_q)));

endmodule

// File: tb/test_dram_tsv_fault_model.sv
`timescale 1ns/1ps
module test_dram_tsv_fault_model;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_write = 1'b0, op_wdata = 1'b0;
  logic [2:0] op_row = '0, op_col = '0;
  logic rd_valid, rd_data, busy, dbg_noaccess;
  logic cfg_we = 1'b0, cfg_ref = 1'b0;
  logic [1:0] cfg_kind = '0;
  logic [3:0] cfg_index = '0;

  always #2.5 clk = ~clk;

  dram_tsv_fault_model i_dram_tsv_fault_model (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_write(op_write),
    .op_row(op_row), .op_col(op_col), .op_wdata(op_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .dbg_noaccess(dbg_noaccess),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_index(cfg_index), .cfg_ref(cfg_ref)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done_flag = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard queues
  bit    exp_d_q[$];
  bit    exp_n_q[$];
  string tag_q[$];
  int    cyc_q[$];

  // Reference model
  bit mdl[8][8];
  int m_kind = 0;
  int m_idx = 0;
  bit m_ref = 0;

  function automatic void chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  function automatic bit on_comp(input int r);
    return (r % 4 == 1) || (r % 4 == 2);
  endfunction

  function automatic bit on_open_bl(input int r, input int c);
    return (m_kind == 2) && (c == m_idx / 2) && (on_comp(r) == bit'(m_idx % 2));
  endfunction

  function automatic void model_write(input int r, input int c, input bit d);
    if (m_kind == 1 && r == m_idx) return;
    if (on_open_bl(r, c)) mdl[r][c] = 0;
    else mdl[r][c] = d;
  endfunction

  function automatic void model_read(input int r, input int c, output bit d, output bit na);
    bit a;
    a = mdl[r][c];
    d = a;
    na = 0;
    if (m_kind == 1 && r == m_idx) begin
      d = m_ref;
      na = 1;
    end else if (m_kind == 1 && m_idx < 8 && (r == m_idx + 1 || r == m_idx - 1)) begin
      if (on_comp(r) == on_comp(m_idx)) begin
        if (a && !mdl[m_idx][c]) begin d = 0; mdl[r][c] = 0; end
      end else begin
        if (!a && !mdl[m_idx][c]) begin d = 1; mdl[r][c] = 1; end
      end
    end else if (on_open_bl(r, c)) begin
      if (c == 0) d = mdl[r][1];
      else if (c == 7) d = mdl[r][6];
      else if (mdl[r][c-1] != mdl[r][c+1]) d = mdl[r][c-1];
      else d = mdl[r][c+1];
    end
  endfunction

  task automatic push_read(input int r, input int c, input string tag);
    bit d, na;
    model_read(r, c, d, na);
    exp_d_q.push_back(d);
    exp_n_q.push_back(na);
    tag_q.push_back(tag);
    cyc_q.push_back(cyc);
    op_valid = 1; op_write = 0; op_row = 3'(r); op_col = 3'(c);
  endtask

  task automatic do_read(input int r, input int c, input string tag);
    push_read(r, c, tag);
    @(posedge clk);
    @(negedge clk);
    op_valid = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic do_write(input int r, input int c, input bit d);
    op_valid = 1; op_write = 1; op_row = 3'(r); op_col = 3'(c); op_wdata = d;
    @(posedge clk);
    @(negedge clk);
    op_valid = 0; op_write = 0;
    model_write(r, c, d);
  endtask

  task automatic set_cfg(input int k, input int idx, input bit rv);
    cfg_we = 1; cfg_kind = 2'(k); cfg_index = 4'(idx); cfg_ref = rv;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0;
    m_kind = (k == 3) ? 0 : k;
    m_idx = idx;
    m_ref = rv;
  endtask

  // Monitor: compare results as the design produces them
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (tag_q.size() == 0) begin
        chk(0, "R2 unexpected result", 1, 0);
      end else begin
        bit ed, en;
        string tg;
        int ic;
        ed = exp_d_q.pop_front();
        en = exp_n_q.pop_front();
        tg = tag_q.pop_front();
        ic = cyc_q.pop_front();
        chk(rd_data == ed, tg, rd_data, ed);
        chk(dbg_noaccess == en, {tg, " noaccess flag"}, dbg_noaccess, en);
        chk(cyc - ic - 1 == 4, "R2 latency", cyc - ic - 1, 4);
      end
    end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      chk(0, "watchdog", 0, 1);
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rd_valid == 0, "R1 rd_valid after reset", rd_valid, 0);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(dbg_noaccess == 0, "R1 flag after reset", dbg_noaccess, 0);
    do_read(5, 5, "R1 cell cleared");
    do_read(2, 0, "R1 no defect active");

    // R2 plain writes and reads
    do_write(0, 0, 1); do_write(1, 1, 1); do_write(6, 7, 1); do_write(3, 2, 0);
    do_read(0, 0, "R2 read 1 row0");
    do_read(1, 1, "R2 read 1 row1");
    do_read(6, 7, "R2 read 1 row6");
    do_read(3, 2, "R2 read 0 row3");
    do_write(0, 0, 0);
    do_read(0, 0, "R2 overwrite to 0");

    // R3 strobe while busy ignored
    push_read(4, 4, "R3 read in flight");
    @(posedge clk); @(negedge clk);
    op_write = 1; op_wdata = 1; op_row = 3'd4; op_col = 3'd4;
    @(posedge clk); @(negedge clk);
    op_valid = 0; op_write = 0;
    while (busy) @(negedge clk);
    do_read(4, 4, "R3 cell untouched by ignored write");

    // Wordline defect at row 2 (complement); row 1 same line, row 3 opposite
    do_write(2, 0, 0); do_write(2, 1, 1); do_write(1, 0, 1); do_write(3, 0, 0);
    do_write(1, 1, 1); do_write(3, 1, 0);
    set_cfg(1, 2, 0);
    do_read(1, 0, "R5 same line 1 vs floating 0");
    do_read(1, 0, "R5 restored as 0");
    do_read(3, 0, "R6 opposite line both 0");
    do_read(3, 0, "R6 restored as 1");
    do_read(1, 1, "R6 floating 1 reads correct");
    do_read(3, 1, "R6 opposite line 0 vs 1 correct");
    do_read(2, 1, "R4 no-access read ref 0");
    do_write(2, 1, 0);
    do_write(1, 0, 1); do_write(3, 0, 0);
    set_cfg(1, 2, 1);
    do_read(2, 0, "R4 no-access read ref 1");
    set_cfg(0, 0, 0);
    do_read(2, 1, "R4 write to open row ignored");
    do_read(2, 0, "R7 floating cell kept");

    // Bitline defect: column 3 true line (index 6)
    do_write(0, 2, 1); do_write(0, 4, 0); do_write(4, 3, 1);
    set_cfg(2, 6, 0);
    do_read(0, 3, "R9 neighbours 1,0 give 1");
    do_write(0, 2, 0); do_write(0, 4, 1);
    do_read(0, 3, "R9 neighbours 0,1 give 0");
    do_write(0, 2, 1);
    do_read(0, 3, "R9 equal neighbours 1");
    do_write(0, 2, 0); do_write(0, 4, 0);
    do_read(0, 3, "R9 equal neighbours 0");
    do_write(1, 3, 1);
    do_read(1, 3, "R8 partner line reads correct");
    do_write(4, 3, 1);
    do_write(0, 3, 1);
    set_cfg(0, 0, 0);
    do_read(4, 3, "R10 held 1 decays to 0");
    do_read(0, 3, "R10 write 1 stores 0");
    do_read(1, 3, "R8 partner line write kept");

    // Edge columns
    do_write(0, 1, 1); do_write(1, 6, 1);
    set_cfg(2, 0, 0);
    do_read(0, 0, "R9 column 0 takes column 1");
    set_cfg(2, 15, 0);
    do_read(1, 7, "R9 last column takes left");
    set_cfg(0, 0, 0);

    // R11 in-flight configuration change
    do_write(5, 2, 1);
    push_read(5, 2, "R11 in-flight read keeps old config");
    @(posedge clk); @(negedge clk);
    op_valid = 0;
    cfg_we = 1; cfg_kind = 2'd1; cfg_index = 4'd5; cfg_ref = 0;
    @(posedge clk); @(negedge clk);
    cfg_we = 0; m_kind = 1; m_idx = 5; m_ref = 0;
    while (busy) @(negedge clk);
    do_read(5, 2, "R11 next read uses new config");
    set_cfg(3, 5, 1);
    do_read(5, 2, "R11 kind 3 acts as none");

    repeat (10) @(negedge clk);
    chk(tag_q.size() == 0, "R2 all results returned", tag_q.size(), 0);
    done_flag = 1;
    report();
    $finish;
  end

endmodule